// File: doc/BRIEF.md
# Configurable Multi-Line Delay Buffer

This block holds the line storage for a vertical video filter with eight taps. A registered 12-bit pixel enters the block and passes through a chain of seven line delays of equal length. Tap 0 is the input register. Taps 1 to 7 are the outputs of the seven delays, so each tap sees the same column one line further back. The last delay also drives a cascade output, which can feed a further instance of the block to make a longer filter. The multipliers that consume the taps sit outside this block.

A length field sets the line length, which is the field value plus 4. The field is clamped at a parameterised maximum. The block has four ways to fill its lines. Delay mode shifts the data in series down the chain. Recirculate mode feeds each line back into itself. Parallel preload writes the input register into every line at once. Cascade mode makes the first line two cycles shorter, to make up for the register stages between chained instances.

An auxiliary field input can take the place of the pixel on tap 0. An optional auxiliary delay of the same length is also available. It extends the chain, or it is preloaded from the auxiliary input. An active-low shift enable freezes all of the storage.

Top module: `vline_delay_chain`

## Requirements
- R1: While reset is asserted, all tap outputs, the cascade output and the auxiliary tap read 0, and they stay 0 after reset is released until data has been shifted in.
- R2: With a length field F no greater than MAX_LEN-4, each line delays its input by exactly F+4 shifts.
- R3: A length field above MAX_LEN-4 gives a line length of MAX_LEN. For example, with MAX_LEN=16, field values 20 and 4095 both give length 16.
- R4: When shift_n is high, the input register, every line, the auxiliary delay and every pointer hold their values, so taps 1 to 7, cout_o and aux_tap_o do not change.
- R5: In delay mode (recirc_i=0, par_load_i=0), line 1 is fed from the input register and each line k>1 from line k-1. cout_o is the output of line 7, which is also tap 7.
- R6: With recirc_i=1, each line writes back its own output. Recirculation takes priority over parallel preload, so the contents repeat with a period equal to the line length.
- R7: With par_load_i=1 and recirc_i=0, every one of the seven lines is fed from the input register on the same shift.
- R8: With cascade_en_i=1, line 1 has length L-2, where L is the length of the other lines.
- R9: taps_o bits [11:0] show the input register when aux_port_en_i=0. They show the auxiliary input register when aux_port_en_i=1. The auxiliary register loads aux_din_i on a shift while the port is enabled, and loads 0 on a shift while it is disabled.
- R10: The auxiliary delay, seen on aux_tap_o, shifts only when aux_line_en_i=1 and shift_n=0. Its input is its own output when recirculating, the auxiliary input register under parallel preload, and line 7 otherwise.
- R11: A line takes a new length value only when its pointer wraps. Lines that are still in progress finish their current pass at the old length.
- R12: din_i is captured on a rising edge with shift_n low, and appears on tap 0 after that edge (when aux_port_en_i=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_n | input | 1 | Active-low shift enable for the input registers and the lines |
| din_i | input | 12 | Pixel input, two's complement |
| aux_din_i | input | 12 | Auxiliary field pixel input |
| len_cfg_i | input | 12 | Line length field; the length is the field plus 4 |
| recirc_i | input | 1 | 1 selects recirculate mode |
| par_load_i | input | 1 | 1 feeds every line from the input register |
| aux_port_en_i | input | 1 | 1 enables the auxiliary input port onto tap 0 |
| aux_line_en_i | input | 1 | 1 enables the auxiliary delay |
| cascade_en_i | input | 1 | 1 shortens line 1 by two |
| taps_o | output | 96 | Eight 12-bit taps; tap k occupies bits [12k+11:12k] |
| cout_o | output | 12 | Cascade output (end of the line chain) |
| aux_tap_o | output | 12 | Output of the auxiliary delay |

## Verification
Each line keeps its own write pointer and latched length. A pointer that wraps too early or too late shows up as a tap carrying a sample from the wrong line. The error appears within one line length of the fault, and it then spreads to every tap further down the chain. The error cascades, because a fault in line k reaches cout_o after 7-k more line lengths.

A wrong source select shows up on the next shift. It appears as a repeated value instead of a recirculated one, or as a copy of tap 0 under parallel preload. The reference model is therefore compared on every cycle, across all taps, cout_o and aux_tap_o, with shift_n toggled at random.

// File: rtl/vld_pkg.sv
package vld_pkg;

    typedef enum logic [1:0] {
        SRC_CHAIN = 2'd0,
        SRC_INPUT = 2'd1,
        SRC_SELF  = 2'd2
    } src_sel_e;

    // Recirculation wins over parallel preload, which wins over chaining.
    function automatic src_sel_e pick_src(input logic recirc, input logic par_load);
        if (recirc)        return SRC_SELF;
        else if (par_load) return SRC_INPUT;
        else               return SRC_CHAIN;
    endfunction

endpackage

// File: rtl/vld_len_calc.sv
module vld_len_calc #(
    parameter int CFG_W   = 12,
    parameter int MAX_LEN = 256,
    parameter int LEN_W   = 9
) (
    input  logic [CFG_W-1:0] len_cfg_i,
    input  logic             cascade_i,
    output logic [LEN_W-1:0] len_main_o,
    output logic [LEN_W-1:0] len_first_o
);
    localparam int unsigned        LIMIT = MAX_LEN - 4;
    localparam logic [LEN_W-1:0]   FOUR  = LEN_W'(4);
    localparam logic [LEN_W-1:0]   TWO   = LEN_W'(2);

    always_comb begin
        if (len_cfg_i > CFG_W'(LIMIT)) begin
            len_main_o = LEN_W'(MAX_LEN);
        end else begin
            len_main_o = LEN_W'(len_cfg_i) + FOUR;
        end
        len_first_o = cascade_i ? (len_main_o - TWO) : len_main_o;
    end

endmodule

// File: rtl/vld_line.sv
module vld_line #(
    parameter int W       = 12,
    parameter int MAX_LEN = 256,
    parameter int LEN_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [W-1:0]     din_i,
    output logic [W-1:0]     dout_o
);
    localparam int             AW  = $clog2(MAX_LEN);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0] ptr;
        logic [LEN_W-1:0] len;
    } ctl_t;

    ctl_t         ctl_d, ctl_q;
    logic [W-1:0] mem_q [MAX_LEN];

    always_comb begin
        ctl_d = ctl_q;
        if (adv_i) begin
            if (ctl_q.ptr == ctl_q.len - ONE) begin
                ctl_d.ptr = '0;
                ctl_d.len = len_i;
            end else begin
                ctl_d.ptr = ctl_q.ptr + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ptr: '0, len: len_i};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_LEN; i++) begin
                mem_q[i] <= '0;
            end
        end else if (adv_i) begin
            mem_q[ctl_q.ptr[AW-1:0]] <= din_i;
        end
    end

    assign dout_o = mem_q[ctl_q.ptr[AW-1:0]];

endmodule

// File: rtl/vline_delay_chain.sv
module vline_delay_chain
    import vld_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int NUM_LINES = 7,
    parameter int CFG_W     = 12,
    parameter int MAX_LEN   = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              shift_n,
    input  logic [DATA_W-1:0]                 din_i,
    input  logic [DATA_W-1:0]                 aux_din_i,
    input  logic [CFG_W-1:0]                  len_cfg_i,
    input  logic                              recirc_i,
    input  logic                              par_load_i,
    input  logic                              aux_port_en_i,
    input  logic                              aux_line_en_i,
    input  logic                              cascade_en_i,
    output logic [(NUM_LINES+1)*DATA_W-1:0]   taps_o,
    output logic [DATA_W-1:0]                 cout_o,
    output logic [DATA_W-1:0]                 aux_tap_o
);
    localparam int NUM_TAPS = NUM_LINES + 1;
    localparam int LEN_W    = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic [DATA_W-1:0] pix;
        logic [DATA_W-1:0] aux;
    } in_t;

    in_t               in_d, in_q;
    logic [LEN_W-1:0]  len_main, len_first;
    logic [DATA_W-1:0] line_out [NUM_LINES];
    logic [DATA_W-1:0] aux_feed;
    logic              shift;
    src_sel_e          src;

    assign shift = !shift_n;
    assign src   = pick_src(recirc_i, par_load_i);

    always_comb begin
        in_d = in_q;
        if (shift) begin
            in_d.pix = din_i;
            in_d.aux = aux_port_en_i ? aux_din_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    vld_len_calc #(
        .CFG_W   (CFG_W),
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_len (
        .len_cfg_i   (len_cfg_i),
        .cascade_i   (cascade_en_i),
        .len_main_o  (len_main),
        .len_first_o (len_first)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [DATA_W-1:0] chain_src;
        logic [DATA_W-1:0] feed;
        logic [LEN_W-1:0]  len_sel;

        if (g == 0) begin : g_head
            assign chain_src = in_q.pix;
            assign len_sel   = len_first;
        end else begin : g_body
            assign chain_src = line_out[g-1];
            assign len_sel   = len_main;
        end

        always_comb begin
            case (src)
                SRC_SELF:  feed = line_out[g];
                SRC_INPUT: feed = in_q.pix;
                default:   feed = chain_src;
            endcase
        end

        vld_line #(
            .W       (DATA_W),
            .MAX_LEN (MAX_LEN),
            .LEN_W   (LEN_W)
        ) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (shift),
            .len_i  (len_sel),
            .din_i  (feed),
            .dout_o (line_out[g])
        );

        assign taps_o[(g+1)*DATA_W +: DATA_W] = line_out[g];
    end

    always_comb begin
        case (src)
            SRC_SELF:  aux_feed = aux_tap_o;
            SRC_INPUT: aux_feed = in_q.aux;
            default:   aux_feed = line_out[NUM_LINES-1];
        endcase
    end

    vld_line #(
        .W       (DATA_W),
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_aux_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (shift && aux_line_en_i),
        .len_i  (len_main),
        .din_i  (aux_feed),
        .dout_o (aux_tap_o)
    );

    assign taps_o[DATA_W-1:0] = aux_port_en_i ? in_q.aux : in_q.pix;
    assign cout_o             = line_out[NUM_LINES-1];

endmodule

// File: rtl/vline_delay_chain_chk.sv
module vline_delay_chain_chk #(
    parameter int W        = 12,
    parameter int NUM_TAPS = 8,
    parameter int MAX_LEN  = 256,
    parameter int LEN_W    = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     shift_n,
    input logic [W-1:0]             din_i,
    input logic [W-1:0]             aux_din_i,
    input logic                     aux_port_en_i,
    input logic                     aux_line_en_i,
    input logic [NUM_TAPS*W-1:0]    taps_o,
    input logic [W-1:0]             cout_o,
    input logic [W-1:0]             aux_tap_o,
    input logic [LEN_W-1:0]         len_main,
    input logic [LEN_W-1:0]         len_first
);
    // R4: no shift leaves every stored tap and the cascade output unchanged
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        shift_n |=> ($stable(taps_o[NUM_TAPS*W-1:W]) && $stable(cout_o)));

    // R12: a captured pixel shows on tap 0 right after the edge
    a_r12_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_n && !aux_port_en_i) |=> (aux_port_en_i || taps_o[W-1:0] == $past(din_i)));

    // R9: with the auxiliary port on, tap 0 carries the auxiliary sample
    a_r9_aux_tap0: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_n && aux_port_en_i) |=> (!aux_port_en_i || taps_o[W-1:0] == $past(aux_din_i)));

    // R10: the auxiliary delay is frozen unless enabled and shifting
    a_r10_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_n || !aux_line_en_i) |=> $stable(aux_tap_o));

    // R3 and R8: lengths from the length calculator stay in the legal range
    a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        (len_main <= LEN_W'(MAX_LEN)) && (len_main >= LEN_W'(4)) && (len_first >= LEN_W'(2)));

endmodule

bind vline_delay_chain vline_delay_chain_chk #(
    .W        (DATA_W),
    .NUM_TAPS (NUM_TAPS),
    .MAX_LEN  (MAX_LEN),
    .LEN_W    (LEN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_n       (shift_n),
    .din_i         (din_i),
    .aux_din_i     (aux_din_i),
    .aux_port_en_i (aux_port_en_i),
    .aux_line_en_i (aux_line_en_i),
    .taps_o        (taps_o),
    .cout_o        (cout_o),
    .aux_tap_o     (aux_tap_o),
    .len_main      (len_main),
    .len_first     (len_first)
);

// File: tb/vline_delay_chain_tb.sv
`timescale 1ns/1ps
module vline_delay_chain_tb;
    localparam int W    = 12;
    localparam int NL   = 7;
    localparam int MAXL = 16;

    logic clk = 0;
    logic rst_n = 1;
    logic shift_n = 1;
    logic [W-1:0] din = 0, aux_din = 0;
    logic [11:0] len_cfg = 0;
    logic recirc = 0, par_load = 0, aux_port_en = 0, aux_line_en = 0, cascade_en = 0;
    logic [(NL+1)*W-1:0] taps;
    logic [W-1:0] cout, aux_tap;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit cmp_en = 0;

    always #5 clk = ~clk;

    vline_delay_chain #(.DATA_W(W), .NUM_LINES(NL), .CFG_W(12), .MAX_LEN(MAXL)) u_dut (
        .clk(clk), .rst_n(rst_n), .shift_n(shift_n), .din_i(din), .aux_din_i(aux_din),
        .len_cfg_i(len_cfg), .recirc_i(recirc), .par_load_i(par_load),
        .aux_port_en_i(aux_port_en), .aux_line_en_i(aux_line_en), .cascade_en_i(cascade_en),
        .taps_o(taps), .cout_o(cout), .aux_tap_o(aux_tap));

    // Behavioural reference: index 0..6 are the lines, 7 is the auxiliary delay
    int m_mem [8][MAXL];
    int m_ptr [8];
    int m_len [8];
    int m_in, m_aux;

    function automatic int want_len(int idx);
        int l;
        l = (len_cfg > MAXL - 4) ? MAXL : len_cfg + 4;
        if (idx == 0 && cascade_en) l = l - 2;
        return l;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) begin
                for (int i = 0; i < MAXL; i++) m_mem[k][i] = 0;
                m_ptr[k] = 0;
                m_len[k] = want_len(k);
            end
            m_in = 0; m_aux = 0;
        end else if (!shift_n) begin
            int o [8];
            int src;
            for (int k = 0; k < 8; k++) o[k] = m_mem[k][m_ptr[k]];
            for (int k = 0; k < 8; k++) begin
                if (k == 7 && !aux_line_en) continue;
                if (recirc)          src = o[k];
                else if (par_load)   src = (k == 7) ? m_aux : m_in;
                else if (k == 0)     src = m_in;
                else                 src = o[k-1];
                m_mem[k][m_ptr[k]] = src;
                if (m_ptr[k] == m_len[k] - 1) begin
                    m_ptr[k] = 0;
                    m_len[k] = want_len(k);
                end else begin
                    m_ptr[k] = m_ptr[k] + 1;
                end
            end
            m_in  = din;
            m_aux = aux_port_en ? aux_din : 0;
        end
    end

    task automatic check_word(string what, int act, int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            n_cmp++;
            check_word("tap0", taps[W-1:0], aux_port_en ? m_aux : m_in);
            for (int k = 1; k <= NL; k++)
                check_word($sformatf("tap%0d", k), taps[k*W +: W], m_mem[k-1][m_ptr[k-1]]);
            check_word("cout", cout, m_mem[NL-1][m_ptr[NL-1]]);
            check_word("aux_tap", aux_tap, m_mem[7][m_ptr[7]]);
        end
    end

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 0;
        @(negedge clk);
        // R1: outputs are zero while reset is held
        n_cmp++;
        if (taps !== '0 || cout !== '0 || aux_tap !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: actual taps %0h cout %0h aux %0h expected 0", taps, cout, aux_tap);
        end
        #1 rst_n = 1;
    endtask

    task automatic run(int n, bit rand_shift);
        repeat (n) begin
            @(negedge clk); #1;
            din     = W'($urandom);
            aux_din = W'($urandom);
            shift_n = rand_shift ? (($urandom % 4) == 0) : 1'b0;
        end
        @(negedge clk); #1;
        shift_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cmp_en = 1;
        cur_req = "R1"; len_cfg = 0; do_reset();
        run(2, 0);
        cur_req = "R2 R5 R12 length 4 series"; run(80, 0);
        cur_req = "R2 R4 length 9 random shift"; len_cfg = 5; do_reset(); run(200, 1);
        cur_req = "R3 field 20 saturates"; len_cfg = 20; do_reset(); run(150, 0);
        cur_req = "R3 field 4095 saturates"; len_cfg = 12'hFFF; do_reset(); run(150, 1);
        cur_req = "R6 recirculate"; len_cfg = 3; do_reset(); run(60, 0);
        recirc = 1; run(40, 0); par_load = 1; run(30, 1); par_load = 0; recirc = 0;
        cur_req = "R7 parallel preload"; len_cfg = 2; do_reset();
        par_load = 1; run(40, 0); par_load = 0; run(60, 1);
        cur_req = "R8 cascade first line short"; len_cfg = 1; cascade_en = 1; do_reset(); run(100, 0);
        run(60, 1); cascade_en = 0;
        cur_req = "R9 aux port tap0"; len_cfg = 0; do_reset();
        aux_port_en = 1; run(30, 1); aux_port_en = 0; run(10, 0);
        cur_req = "R10 aux delay chained"; aux_line_en = 1; run(80, 1);
        cur_req = "R10 aux delay preload"; aux_port_en = 1; par_load = 1; run(30, 0);
        par_load = 0; recirc = 1; run(30, 1); recirc = 0;
        aux_line_en = 0; run(20, 0); aux_port_en = 0;
        cur_req = "R11 length change at wrap"; len_cfg = 2; do_reset(); run(31, 0);
        len_cfg = 9; run(70, 0); len_cfg = 0; run(45, 1);
        cmp_en = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule